// File: doc/BRIEF.md
# Start-Condition Watchdog Supervisor

This block watches over a host processor and drives one active-high reset line to it. Reset is asserted while a digital supply-good flag from an external comparator is low. Once the flag returns, reset is held for a fixed hold-off time. A watchdog counter runs while the host is out of reset. The only thing that restarts it is a start condition on a two-wire serial bus, meaning SDA falls while SCL is high. If the counter runs out, the block issues a reset pulse of the same hold-off length and then starts the count again.

A two-bit select input chooses among three timeout lengths or turns the watchdog off. All timing comes from a slow tick input, so periods are counted in ticks: with a 1 ms tick the defaults give 1750, 750 and 250 ms timeouts and a 250 ms hold-off. A simulation can shrink them through parameters. SDA, SCL and the supply flag each pass through a two-flop synchronizer before any decision is made.

Top module: `wdog_supervisor`

## Requirements
- R1: While rst_ni is low, host_rst_o is 1. After rst_ni rises, host_rst_o stays 1 while supply_ok_i is low.
- R2: Suppose supply_ok_i rises in the cycle driven before clock edge c+1. Then host_rst_o is 1 through the edge c+2+HOLD_TICKS and 0 after the edge c+3+HOLD_TICKS, with a tick every cycle.
- R3: The hold-off counts only while the synchronized supply flag is high without a break. A drop during the hold-off restarts the full hold-off when the flag comes back.
- R4: Three clock edges after supply_ok_i falls, host_rst_o is 1. It stays 1 for as long as supply_ok_i is low.
- R5: While the host is out of reset, wd_sel_i chooses the timeout. Code 2'b00 gives LONG_TICKS, 2'b01 gives MID_TICKS and 2'b10 gives SHORT_TICKS. The count runs from the last restart, from release, or from leaving the off code. At expiry host_rst_o goes to 1.
- R6: With wd_sel_i = 2'b11 the watchdog never asserts host_rst_o, however long the host runs.
- R7: A start condition restarts the watchdog at its full period. A start condition is SDA falling while SCL is high, seen after synchronization, so the restart takes effect three edges after SDA is driven low.
- R8: An SDA fall while SCL is low does not restart the watchdog.
- R9: A watchdog expiry holds host_rst_o at 1 for exactly HOLD_TICKS ticks. After that the watchdog counts again from its full period.
- R10: A start condition that arrives while host_rst_o is 1 has no effect. It does not shorten or lengthen the reset pulse, and it does not change when the next expiry happens.
- R11: The watchdog and the hold-off advance only on cycles with tick_i high. Without ticks, neither one expires nor finishes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timebase tick, one clock cycle wide |
| wd_sel_i | input | 2 | Timeout select: 00 long, 01 mid, 10 short, 11 off |
| sda_i | input | 2-wire bus data line, asynchronous |
| scl_i | input | 1 | 2-wire bus clock line, asynchronous |
| supply_ok_i | input | 1 | Supply-good flag from the comparator, asynchronous |
| host_rst_o | output | 1 | Active-high reset to the host |

## Verification
The bench predicts the exact cycle of every edge on host_rst_o, taking the synchronizer and counter latency into account. An off-by-one in the hold-off or timeout counters therefore moves an edge and fails. A two-cycle supply glitch during the hold-off catches a design that resumes the count instead of restarting it, because its reset would release about ten cycles early. SDA falls with SCL low and start conditions sent during a reset pulse must leave every later edge where it was. A design that accepts them pushes the next expiry late. Holding the tick low for a long time exposes counters that run on the clock instead of the tick.

// File: rtl/wdsup_pkg.sv
package wdsup_pkg;
  typedef enum logic [1:0] {
    WD_LONG  = 2'b00,
    WD_MID   = 2'b01,
    WD_SHORT = 2'b10,
    WD_OFF   = 2'b11
  } wd_sel_e;

  typedef enum logic [1:0] {
    SUP_DOWN = 2'b00,
    SUP_HOLD = 2'b01,
    SUP_RUN  = 2'b10
  } sup_state_e;
endpackage

// File: rtl/wdsup_sync.sv
module wdsup_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] sr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sr_q <= '0;
      else         sr_q <= {sr_q[STAGES-2:0], d_i[i]};
    end
    assign q_o[i] = sr_q[STAGES-1];
  end
endmodule

// File: rtl/wdsup_start_det.sv
module wdsup_start_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sda_i,
  input  logic scl_i,
  output logic start_o
);
  logic sda_q, scl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sda_q <= 1'b0;
      scl_q <= 1'b0;
    end else begin
      sda_q <= sda_i;
      scl_q <= scl_i;
    end
  end

  // SDA falls while SCL is high before and after the edge
  assign start_o = sda_q & ~sda_i & scl_q & scl_i;
endmodule

// File: rtl/wdsup_timer.sv
module wdsup_timer import wdsup_pkg::*; #(
  parameter int unsigned LONG_TICKS  = 1750,
  parameter int unsigned MID_TICKS   = 750,
  parameter int unsigned SHORT_TICKS = 250,
  localparam int unsigned CNT_W      = $clog2(LONG_TICKS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             kick_i,
  input  wd_sel_e          sel_i,
  output logic             expire_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, limit;
  logic             en;

  always_comb begin
    unique case (sel_i)
      WD_LONG:  limit = CNT_W'(LONG_TICKS);
      WD_MID:   limit = CNT_W'(MID_TICKS);
      WD_SHORT: limit = CNT_W'(SHORT_TICKS);
      default:  limit = CNT_W'(LONG_TICKS);
    endcase
  end

  assign en       = (sel_i != WD_OFF);
  // cnt_q holds elapsed ticks; an up-count lets a select change act at once
  assign expire_o = run_i & en & tick_i & ~kick_i & (cnt_q >= limit - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 cnt_q <= '0;
    else if (!run_i || !en || kick_i || expire_o) cnt_q <= '0;
    else if (tick_i)                             cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/wdsup_rstctl.sv
module wdsup_rstctl import wdsup_pkg::*; #(
  parameter int unsigned HOLD_TICKS = 250,
  localparam int unsigned HCW       = $clog2(HOLD_TICKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic supply_i,
  input  logic expire_i,
  output logic run_o
);
  sup_state_e     state_q;
  logic [HCW-1:0] hcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SUP_DOWN;
      hcnt_q  <= '0;
    end else begin
      unique case (state_q)
        SUP_DOWN: begin
          hcnt_q <= '0;
          if (supply_i) state_q <= SUP_HOLD;
        end
        SUP_HOLD: begin
          if (!supply_i) begin
            state_q <= SUP_DOWN;
          end else if (tick_i) begin
            if (hcnt_q == HCW'(HOLD_TICKS - 1)) state_q <= SUP_RUN;
            else                                 hcnt_q  <= hcnt_q + HCW'(1);
          end
        end
        SUP_RUN: begin
          hcnt_q <= '0;
          if (!supply_i)     state_q <= SUP_DOWN;
          else if (expire_i) state_q <= SUP_HOLD;
        end
        default: state_q <= SUP_DOWN;
      endcase
    end
  end

  assign run_o = (state_q == SUP_RUN);
endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor import wdsup_pkg::*; #(
  parameter int unsigned LONG_TICKS  = 1750,
  parameter int unsigned MID_TICKS   = 750,
  parameter int unsigned SHORT_TICKS = 250,
  parameter int unsigned HOLD_TICKS  = 250,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CNT_W      = $clog2(LONG_TICKS + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [1:0] wd_sel_i,
  input  logic       sda_i,
  input  logic       scl_i,
  input  logic       supply_ok_i,
  output logic       host_rst_o
);
  logic [2:0]       raw, synced;
  logic             sda_s, scl_s, sup_s;
  logic             kick, expire, run;
  logic [CNT_W-1:0] wd_cnt;

  assign raw = {supply_ok_i, scl_i, sda_i};

  wdsup_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (synced)
  );

  assign sda_s = synced[0];
  assign scl_s = synced[1];
  assign sup_s = synced[2];

  wdsup_start_det u_start (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sda_i  (sda_s),
    .scl_i  (scl_s),
    .start_o(kick)
  );

  wdsup_timer #(
    .LONG_TICKS (LONG_TICKS),
    .MID_TICKS  (MID_TICKS),
    .SHORT_TICKS(SHORT_TICKS)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .run_i   (run),
    .kick_i  (kick),
    .sel_i   (wd_sel_e'(wd_sel_i)),
    .expire_o(expire),
    .cnt_o   (wd_cnt)
  );

  wdsup_rstctl #(.HOLD_TICKS(HOLD_TICKS)) u_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .supply_i(sup_s),
    .expire_i(expire),
    .run_o   (run)
  );

  assign host_rst_o = ~run;
endmodule

// File: rtl/wdog_supervisor_chk.sv
module wdog_supervisor_chk #(
  parameter int unsigned LONG_TICKS = 1750,
  localparam int unsigned CNT_W     = $clog2(LONG_TICKS + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic [1:0]       wd_sel_i,
  input logic             sup_s,
  input logic             run,
  input logic             kick,
  input logic             expire,
  input logic [CNT_W-1:0] cnt,
  input logic             host_rst_o
);
  p_low_supply_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sup_s |=> host_rst_o);

  p_release_supply_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(host_rst_o) |-> $past(sup_s));

  p_off_no_expire_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |-> wd_sel_i != 2'b11);

  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt < CNT_W'(LONG_TICKS));

  p_kick_reload_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && kick) |=> cnt == '0);

  p_expire_reset_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> host_rst_o);

  p_hold_kick_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_rst_o && kick) |=> cnt == '0);

  p_no_tick_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !tick_i && !kick && wd_sel_i != 2'b11) |=> $stable(cnt));
endmodule

bind wdog_supervisor wdog_supervisor_chk #(.LONG_TICKS(LONG_TICKS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .wd_sel_i  (wd_sel_i),
  .sup_s     (sup_s),
  .run       (run),
  .kick      (kick),
  .expire    (expire),
  .cnt       (wd_cnt),
  .host_rst_o(host_rst_o)
);

// File: tb/wdog_supervisor_bench.sv
module wdog_supervisor_bench;
  localparam int LONG  = 60;
  localparam int MID   = 30;
  localparam int SHORT = 10;
  localparam int HOLD  = 20;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_en = 1'b1;
  logic [1:0] wd_sel_i = 2'b11;
  logic       sda_i = 1'b1;
  logic       scl_i = 1'b1;
  logic       supply_ok_i = 1'b0;
  logic       host_rst_o;

  always #4 clk_i = ~clk_i;

  wdog_supervisor #(
    .LONG_TICKS(LONG), .MID_TICKS(MID), .SHORT_TICKS(SHORT), .HOLD_TICKS(HOLD)
  ) u_wdog_supervisor (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_en),
    .wd_sel_i   (wd_sel_i),
    .sda_i      (sda_i),
    .scl_i      (scl_i),
    .supply_ok_i(supply_ok_i),
    .host_rst_o (host_rst_o)
  );

  typedef struct {
    int    due;
    logic  val;
    string tag;
  } item_t;

  item_t q[$];
  int    cyc = 0;
  int    n_run = 0;
  int    n_fail = 0;
  bit    done = 0;

  // monitor: compare scheduled expectations just after each falling edge
  initial begin
    forever begin
      @(negedge clk_i);
      cyc++;
      #1;
      while (q.size() > 0 && q[0].due <= cyc) begin
        item_t it;
        it = q.pop_front();
        n_run++;
        if (host_rst_o !== it.val) begin
          n_fail++;
          $display("FAIL %s: host_rst_o=%0b expected %0b at cycle %0d",
                   it.tag, host_rst_o, it.val, cyc);
        end
      end
    end
  end

  task automatic step();
    @(negedge clk_i);
    #2;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic exp_abs(input int due, input logic val, input string tag);
    item_t it;
    it.due = due; it.val = val; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic exp_in(input int off, input logic val, input string tag);
    exp_abs(cyc + off, val, tag);
  endtask

  task automatic drain();
    while (q.size() > 0) step();
  endtask

  // wait until reset is released; returns the first cycle it reads 0
  task automatic wait_rel(output int c0);
    int n;
    n = 0;
    while (host_rst_o !== 1'b0 && n < 500) begin
      step();
      n++;
    end
    if (n >= 500) begin
      n_run++; n_fail++;
      $display("FAIL release: host_rst_o=%0b expected 0 within 500 cycles", host_rst_o);
    end
    c0 = cyc;
  endtask

  // start condition: SDA falls while SCL high, then a stop
  task automatic send_start();
    sda_i = 1'b0; idle(4);
    scl_i = 1'b0; idle(2);
    sda_i = 1'b1; idle(2);
    scl_i = 1'b1; idle(1);
  endtask

  initial begin
    int c0, c1;
    // R1 reset state
    idle(3);
    exp_in(1, 1'b1, "R1");
    idle(2);
    rst_ni = 1'b1;
    exp_in(30, 1'b1, "R1");
    idle(31);

    // R2 power-on hold-off
    supply_ok_i = 1'b1;
    exp_in(HOLD + 2, 1'b1, "R2");
    exp_in(HOLD + 3, 1'b0, "R2");
    idle(HOLD + 4);

    // R6 watchdog off
    exp_in(50, 1'b0, "R6");
    exp_in(100, 1'b0, "R6");
    exp_in(4 * LONG, 1'b0, "R6");
    idle(4 * LONG + 1);

    // R4 low supply
    supply_ok_i = 1'b0;
    exp_in(2, 1'b0, "R4");
    exp_in(3, 1'b1, "R4");
    exp_in(100, 1'b1, "R4");
    idle(101);

    // R3 glitch during hold-off restarts it
    supply_ok_i = 1'b1;
    idle(10);
    supply_ok_i = 1'b0;
    idle(2);
    supply_ok_i = 1'b1;
    exp_in(HOLD + 2, 1'b1, "R3");
    exp_in(HOLD + 3, 1'b0, "R3");
    idle(HOLD + 4);

    // R5 short timeout, R9 pulse length and restart from full
    wd_sel_i = 2'b10;
    exp_in(SHORT - 1, 1'b0, "R5");
    exp_in(SHORT, 1'b1, "R5");
    exp_in(SHORT + HOLD - 1, 1'b1, "R9");
    exp_in(SHORT + HOLD, 1'b0, "R9");
    exp_in(2 * SHORT + HOLD - 1, 1'b0, "R9");
    exp_in(2 * SHORT + HOLD, 1'b1, "R9");
    idle(2 * SHORT + HOLD + 1);
    wd_sel_i = 2'b11;
    wait_rel(c0);

    // R5 mid and long timeouts
    wd_sel_i = 2'b01;
    exp_in(MID - 1, 1'b0, "R5");
    exp_in(MID, 1'b1, "R5");
    idle(MID + 1);
    wd_sel_i = 2'b00;
    wait_rel(c1);
    exp_in(LONG - 1, 1'b0, "R5");
    exp_in(LONG, 1'b1, "R5");
    idle(LONG + 1);
    wd_sel_i = 2'b11;
    wait_rel(c0);

    // R7 start conditions keep the host running
    wd_sel_i = 2'b01;
    exp_abs(c0 + 45, 1'b0, "R7");
    exp_abs(c0 + 70, 1'b0, "R7");
    exp_abs(c0 + 92, 1'b0, "R7");
    exp_abs(c0 + 93, 1'b1, "R7");
    idle(10); send_start();
    while (cyc < c0 + 35) step();
    send_start();
    while (cyc < c0 + 60) step();
    send_start();
    drain();
    wd_sel_i = 2'b11;
    wait_rel(c0);

    // R8 SDA fall with SCL low ignored; R10 start during reset pulse ignored
    wd_sel_i = 2'b10;
    exp_abs(c0 + SHORT - 1, 1'b0, "R8");
    exp_abs(c0 + SHORT, 1'b1, "R8");
    exp_abs(c0 + SHORT + HOLD - 1, 1'b1, "R10");
    exp_abs(c0 + SHORT + HOLD, 1'b0, "R10");
    exp_abs(c0 + 2 * SHORT + HOLD - 1, 1'b0, "R10");
    exp_abs(c0 + 2 * SHORT + HOLD, 1'b1, "R10");
    idle(2); scl_i = 1'b0;
    idle(2); sda_i = 1'b0;
    idle(2); sda_i = 1'b1;
    idle(1); scl_i = 1'b1;
    while (cyc < c0 + 15) step();
    send_start();
    drain();
    wd_sel_i = 2'b11;
    wait_rel(c0);

    // R11 no tick, no progress
    tick_en = 1'b0;
    wd_sel_i = 2'b10;
    exp_in(50, 1'b0, "R11");
    exp_in(100, 1'b0, "R11");
    idle(100);
    tick_en = 1'b1;
    exp_in(SHORT - 1, 1'b0, "R11");
    exp_in(SHORT, 1'b1, "R11");
    idle(SHORT);
    tick_en = 1'b0;
    exp_in(50, 1'b1, "R11");
    idle(50);
    tick_en = 1'b1;
    exp_in(HOLD - 1, 1'b1, "R11");
    exp_in(HOLD, 1'b0, "R11");
    drain();
    idle(2);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule